// File: doc/BRIEF.md
# Multi-Mode Page Table Walker

The block turns a virtual address into a physical address by reading page-table entries from memory one at a time. The caller presents the virtual address, the paging controls (paging enable, physical-address-extension enable, large-page enable for the 32-bit format, five-level enable, long-mode-active) and the table root register, then pulses `start`. The walker picks one of five formats: translation off, two-level 32-bit tables with 4-byte entries, three-level extended tables with 8-byte entries, four-level long-mode tables, or five-level long-mode tables.

Each table read goes out on a simple memory port. The port raises a request with an address and an entry-width flag, holds it, and waits for a response-valid strobe carrying the entry. A walk stops early on a large-page entry. It ends in a fault when an entry is not present or when a long-mode address is not in canonical form. Every table address passes through an address-line-20 mask before it leaves the block, so an emulated wrap-around at 1 MB can be applied to table reads. The result is a one-cycle `done` strobe. The fault flag, the physical address and a page-size code are held with it until the next walk completes.

Top module: `ptw_top`

## Requirements
- R1: With `pg_en` low, a walk issues no memory read, `done` rises on the cycle after the start edge, `pg_size` is 0, and `pa` equals `va` ANDed with `a20_mask`.
- R2: In 32-bit mode (`pg_en` high, `pae_en` low), the directory entry address is `cr3` with bits 11:0 cleared plus `va[31:22]*4`. The table entry address is the directory entry with bits 11:0 cleared plus `va[21:12]*4`. Reads use `mem_wide`=0 and only data bits 31:0.
- R3: In 32-bit mode, a directory entry with bit 7 set and `pse_en` high ends the walk as a 4 MB page (`pg_size`=2). `pa` bits 39:32 come from entry bits 20:13, bits 31:22 come from entry bits 31:22, and bits 21:0 come from `va`. With `pse_en` low, bit 7 is ignored and the walk continues to the table level.
- R4: In extended mode (`pae_en` high, `lm_active` low), the first table base is `cr3` with bits 4:0 cleared, and its entry offset is `va[31:30]*8`. The next two levels use 9-bit indices at `va` bit 21 and `va` bit 12, with 8-byte entries (`mem_wide`=1). In this mode, bit 7 of the first-level entry is ignored.
- R5: In extended or long mode, a second-to-last-level entry with bit 7 set ends the walk as a 2 MB page (`pg_size`=1).
- R6: In long mode (`pae_en` and `lm_active` high), the walk starts at `cr3` with bits 11:0 cleared. It indexes 9 bits at `va` bits 39, 30, 21 and 12. With `la57_en` high, it first adds a level indexed by `va[56:48]`.
- R7: In long mode, a third-to-last-level entry with bit 7 set ends the walk as a 1 GB page (`pg_size`=3).
- R8: In long mode, a walk whose `va[63:47]` (or `va[63:56]` with `la57_en`) are not all equal faults on the cycle after the start edge, without any memory read.
- R9: An entry read with bit 0 clear ends the walk at once with `fault` high and `pa` zero.
- R10: The final address is the entry frame (bits 51:12) with the bits below the page size cleared, ORed with the low bits of `va` inside the page. Entry bits 63:52 and 11:0 do not affect it.
- R11: Every table address equals its base plus offset ANDed with `a20_mask`. With translation off or in 32-bit mode, the final frame is ANDed with the mask too.
- R12: After reset, `busy`, `done` and `mem_req` are low. A walk keeps exactly one request outstanding, with `mem_req` and `mem_addr` held until `mem_rsp_valid`. `start` while `busy` is ignored. `done` is a one-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| va | input | 64 | Virtual address |
| cr3 | input | PA_W | Table root register |
| a20_mask | input | PA_W | Mask ANDed into every table address |
| pg_en | input | 1 | Paging enable |
| pae_en | input | 1 | Extended (8-byte entry) tables enable |
| pse_en | input | 1 | 4 MB pages enable in 32-bit mode |
| la57_en | input | 1 | Five-level long-mode tables |
| lm_active | input | 1 | Long mode active |
| mem_req | output | 1 | Table read request, held until response |
| mem_addr | output | PA_W | Table entry byte address |
| mem_wide | output | 1 | 1 = 8-byte entry, 0 = 4-byte entry |
| mem_rsp_valid | input | 1 | Response strobe for the outstanding read |
| mem_rsp_data | input | 64 | Entry read from memory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Walk ended in a fault |
| pa | output | PA_W | Physical address result |
| pg_size | output | 2 | 0=4 KB, 1=2 MB, 2=4 MB, 3=1 GB |

## Verification
The bench builds the walker with `PA_W` = 52, the widest frame the entry format carries. With that width, 1 GB and 4 MB frames above 4 GB stay visible at the `pa` port, and the bits the 4 MB format carries above bit 31 can be checked. The address-line-20 mask is exercised both cleared and set. A shared memory image holds tables for every mode, so one vector list can walk through all page sizes, both canonical checks and non-present entries at the first and last levels. Responses come back with added wait states to expose any change in the held request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        MODE_OFF = 3'd0,
        MODE_W32 = 3'd1,
        MODE_PAE = 3'd2,
        MODE_LM4 = 3'd3,
        MODE_LM5 = 3'd4
    } pmode_e;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_4M = 2'd2,
        PG_1G = 2'd3
    } pgsz_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } wstate_e;

    typedef logic [2:0] lvl_t;

    localparam int          PRESENT_BIT = 0;
    localparam int          PS_BIT      = 7;
    localparam logic [63:0] FRAME_MASK  = 64'h000F_FFFF_FFFF_F000;

    function automatic logic [5:0] size_shift(pgsz_e s);
        case (s)
            PG_2M:   return 6'd21;
            PG_4M:   return 6'd22;
            PG_1G:   return 6'd30;
            default: return 6'd12;
        endcase
    endfunction

    // vpn holds va[56:12]; result is the byte offset of the entry in its table
    function automatic logic [11:0] entry_offset(pmode_e m, lvl_t l, logic [44:0] vpn);
        logic [8:0] idx;
        case (l)
            3'd0:    idx = vpn[8:0];
            3'd1:    idx = vpn[17:9];
            3'd2:    idx = vpn[26:18];
            3'd3:    idx = vpn[35:27];
            default: idx = vpn[44:36];
        endcase
        if (m == MODE_W32)
            return (l == 3'd1) ? {vpn[19:10], 2'b00} : {vpn[9:0], 2'b00};
        if (m == MODE_PAE && l == 3'd2)
            return {7'b0, vpn[19:18], 3'b000};
        return {idx, 3'b000};
    endfunction

    function automatic logic is_canonical(logic [63:0] va, logic five_lvl);
        if (five_lvl)
            return (&va[63:56]) || !(|va[63:56]);
        return (&va[63:47]) || !(|va[63:47]);
    endfunction

endpackage

// File: rtl/ptw_mode_decode.sv
module ptw_mode_decode
    import ptw_pkg::*;
(
    input  logic   pg_en,
    input  logic   pae_en,
    input  logic   la57_en,
    input  logic   lm_active,
    output pmode_e mode,
    output lvl_t   top_lvl
);
    always_comb begin
        if (!pg_en) begin
            mode    = MODE_OFF;
            top_lvl = 3'd0;
        end else if (!pae_en) begin
            mode    = MODE_W32;
            top_lvl = 3'd1;
        end else if (!lm_active) begin
            mode    = MODE_PAE;
            top_lvl = 3'd2;
        end else if (la57_en) begin
            mode    = MODE_LM5;
            top_lvl = 3'd4;
        end else begin
            mode    = MODE_LM4;
            top_lvl = 3'd3;
        end
    end
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  pmode_e            mode,
    input  lvl_t              lvl,
    input  logic [63:0]       base,
    input  logic [44:0]       vpn,
    input  logic [63:0]       a20,
    output logic [PA_W-1:0]   addr
);
    logic [63:0] full;

    assign full = (base + {52'b0, entry_offset(mode, lvl, vpn)}) & a20;
    assign addr = PA_W'(full);
endmodule

// File: rtl/ptw_pa_form.sv
module ptw_pa_form
    import ptw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  pmode_e          mode,
    input  pgsz_e           size,
    input  logic [63:0]     va,
    input  logic [63:0]     entry,
    input  logic [63:0]     a20,
    output logic [PA_W-1:0] pa
);
    logic [63:0] src;
    logic [63:0] keep;
    logic [63:0] full;

    always_comb begin
        if (mode == MODE_OFF) begin
            src = va & a20;
        end else if (mode == MODE_W32) begin
            if (size == PG_4M)
                src = {24'b0, entry[20:13], entry[31:0]} & a20;
            else
                src = {32'b0, entry[31:0]} & a20;
        end else begin
            src = entry;
        end
        keep = (64'd1 << size_shift(size)) - 64'd1;
        full = (src & FRAME_MASK & ~keep) | (va & keep);
    end

    assign pa = PA_W'(full);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [63:0]     va,
    input  logic [PA_W-1:0] cr3,
    input  logic [PA_W-1:0] a20_mask,
    input  logic            pg_en,
    input  logic            pae_en,
    input  logic            pse_en,
    input  logic            la57_en,
    input  logic            lm_active,
    output logic            mem_req,
    output logic [PA_W-1:0] mem_addr,
    output logic            mem_wide,
    input  logic            mem_rsp_valid,
    input  logic [63:0]     mem_rsp_data,
    output logic            busy,
    output logic            done,
    output logic            fault,
    output logic [PA_W-1:0] pa,
    output logic [1:0]      pg_size
);
    localparam int XPAD = 64 - PA_W;

    // widened controls
    logic [63:0] a20_in_ext;
    logic [63:0] cr3_ext;
    assign a20_in_ext = {{XPAD{1'b1}}, a20_mask};
    assign cr3_ext    = {{XPAD{1'b0}}, cr3};

    // mode decode of live inputs
    pmode_e dec_mode;
    lvl_t   dec_top;
    ptw_mode_decode u_dec (
        .pg_en     (pg_en),
        .pae_en    (pae_en),
        .la57_en   (la57_en),
        .lm_active (lm_active),
        .mode      (dec_mode),
        .top_lvl   (dec_top)
    );

    logic        dec_long;
    logic        canon_ok;
    logic [63:0] first_base;
    assign dec_long = (dec_mode == MODE_LM4) || (dec_mode == MODE_LM5);
    assign canon_ok = is_canonical(va, dec_mode == MODE_LM5);

    always_comb begin
        case (dec_mode)
            MODE_W32: first_base = {32'b0, cr3_ext[31:12], 12'b0};
            MODE_PAE: first_base = cr3_ext & ~64'h1F;
            default:  first_base = cr3_ext & FRAME_MASK;
        endcase
    end

    // walk state
    wstate_e         state;
    pmode_e          mode_q;
    lvl_t            lvl_q;
    logic [63:0]     base_q;
    logic [63:0]     va_q;
    logic [63:0]     a20_q;
    logic            pse_q;
    logic            done_q;
    logic            fault_q;
    pgsz_e           size_q;
    logic [PA_W-1:0] pa_q;

    logic long_q;
    assign long_q = (mode_q == MODE_LM4) || (mode_q == MODE_LM5);

    // entry decode
    logic [63:0] ent;
    logic        ent_present;
    logic        ent_leaf;
    pgsz_e       leaf_size;
    logic [63:0] next_base;

    always_comb begin
        ent         = (mode_q == MODE_W32) ? {32'b0, mem_rsp_data[31:0]} : mem_rsp_data;
        ent_present = ent[PRESENT_BIT];
        ent_leaf    = 1'b0;
        leaf_size   = PG_4K;
        if (lvl_q == 3'd0) begin
            ent_leaf = 1'b1;
        end else if (lvl_q == 3'd1 && ent[PS_BIT] && (mode_q != MODE_W32 || pse_q)) begin
            ent_leaf  = 1'b1;
            leaf_size = (mode_q == MODE_W32) ? PG_4M : PG_2M;
        end else if (lvl_q == 3'd2 && ent[PS_BIT] && long_q) begin
            ent_leaf  = 1'b1;
            leaf_size = PG_1G;
        end
        next_base = (mode_q == MODE_W32) ? {32'b0, ent[31:12], 12'b0} : (ent & FRAME_MASK);
    end

    // table address
    ptw_entry_addr #(.PA_W(PA_W)) u_addr (
        .mode (mode_q),
        .lvl  (lvl_q),
        .base (base_q),
        .vpn  (va_q[56:12]),
        .a20  (a20_q),
        .addr (mem_addr)
    );

    // final address: live inputs while idle (translation off), latched during a walk
    logic            idle;
    pmode_e          pf_mode;
    pgsz_e           pf_size;
    logic [63:0]     pf_va;
    logic [63:0]     pf_a20;
    logic [PA_W-1:0] pf_pa;

    assign idle    = (state == ST_IDLE);
    assign pf_mode = idle ? dec_mode   : mode_q;
    assign pf_size = idle ? PG_4K      : leaf_size;
    assign pf_va   = idle ? va         : va_q;
    assign pf_a20  = idle ? a20_in_ext : a20_q;

    ptw_pa_form #(.PA_W(PA_W)) u_pa (
        .mode  (pf_mode),
        .size  (pf_size),
        .va    (pf_va),
        .entry (ent),
        .a20   (pf_a20),
        .pa    (pf_pa)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            mode_q  <= MODE_OFF;
            lvl_q   <= 3'd0;
            base_q  <= '0;
            va_q    <= '0;
            a20_q   <= '1;
            pse_q   <= 1'b0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            size_q  <= PG_4K;
            pa_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q <= dec_mode;
                        lvl_q  <= dec_top;
                        base_q <= first_base;
                        va_q   <= va;
                        a20_q  <= a20_in_ext;
                        pse_q  <= pse_en;
                        if (dec_mode == MODE_OFF) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            size_q  <= PG_4K;
                            pa_q    <= pf_pa;
                        end else if (dec_long && !canon_ok) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            size_q  <= PG_4K;
                            pa_q    <= '0;
                        end else begin
                            state <= ST_WALK;
                        end
                    end
                end
                default: begin
                    if (mem_rsp_valid) begin
                        if (!ent_present) begin
                            state   <= ST_IDLE;
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            size_q  <= PG_4K;
                            pa_q    <= '0;
                        end else if (ent_leaf) begin
                            state   <= ST_IDLE;
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            size_q  <= leaf_size;
                            pa_q    <= pf_pa;
                        end else begin
                            base_q <= next_base;
                            lvl_q  <= lvl_q - 3'd1;
                        end
                    end
                end
            endcase
        end
    end

    assign mem_req  = (state == ST_WALK);
    assign mem_wide = (mode_q != MODE_W32);
    assign busy     = (state == ST_WALK);
    assign done     = done_q;
    assign fault    = fault_q;
    assign pa       = pa_q;
    assign pg_size  = size_q;

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr));

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !mem_req);

    // R12
    walk_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R9
    fault_pa_chk: assert property (@(posedge clk) disable iff (rst)
        done && fault |-> pa == '0);

    // R11
    a20_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (({{XPAD{1'b0}}, mem_addr} & ~a20_q) == 64'd0));

    // R2
    entry_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00) && (!mem_wide || !mem_addr[2]));

    // R8
    noncanon_chk: assert property (@(posedge clk) disable iff (rst)
        idle && start && dec_long && !canon_ok |=> done && fault && !busy);

endmodule

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
    localparam int PA_W   = 52;
    localparam int CLK_NS = 10;

    typedef struct packed {
        logic [4:0]  ctl;       // {pg, pae, pse, la57, lm}
        logic        a20_off;
        logic [63:0] cr3;
        logic [63:0] va;
        logic        exp_fault;
        logic [1:0]  exp_size;
        logic [63:0] exp_pa;
        logic [3:0]  exp_reads;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R1 translation off
        '{5'b00000, 1'b0, 64'h0, 64'h0000_0000_0012_3456, 1'b0, 2'd0, 64'h0000_0000_0012_3456, 4'd0, 4'd1},
        // R11 translation off with bit 20 masked
        '{5'b00000, 1'b1, 64'h0, 64'h0000_0000_0012_3456, 1'b0, 2'd0, 64'h0000_0000_0002_3456, 4'd0, 4'd11},
        // R2 32-bit two-level
        '{5'b10100, 1'b0, 64'h1000, 64'h0000_0000_0040_3123, 1'b0, 2'd0, 64'h0000_0000_0005_5123, 4'd2, 4'd2},
        // R3 4 MB page with high bits
        '{5'b10100, 1'b0, 64'h1000, 64'h0000_0000_0080_0456, 1'b0, 2'd2, 64'h0000_0012_0C40_0456, 4'd1, 4'd3},
        // R3 large-page bit ignored without pse
        '{5'b10000, 1'b0, 64'h1000, 64'h0000_0000_0080_0456, 1'b0, 2'd0, 64'h0000_0000_0007_7456, 4'd2, 4'd3},
        // R9 absent directory entry
        '{5'b10100, 1'b0, 64'h1000, 64'h0000_0000_00C0_0000, 1'b1, 2'd0, 64'h0, 4'd1, 4'd9},
        // R11 table address masked
        '{5'b10100, 1'b1, 64'h0010_1000, 64'h0000_0000_0040_3123, 1'b0, 2'd0, 64'h0000_0000_0005_5123, 4'd2, 4'd11},
        // R4 extended three-level, R10 top entry bits ignored
        '{5'b11000, 1'b0, 64'h303F, 64'h0000_0000_8020_1ABC, 1'b0, 2'd0, 64'h0000_0000_0006_6ABC, 4'd3, 4'd4},
        // R5 extended 2 MB
        '{5'b11000, 1'b0, 64'h3020, 64'h0000_0000_8040_0123, 1'b0, 2'd1, 64'h0000_0012_3460_0123, 4'd2, 4'd5},
        // R6 four-level
        '{5'b11001, 1'b0, 64'h10ABC, 64'h0000_0080_4020_1345, 1'b0, 2'd0, 64'h0000_000A_BCDE_F345, 4'd4, 4'd6},
        // R7 1 GB
        '{5'b11001, 1'b0, 64'h10000, 64'h0000_0080_8000_0777, 1'b0, 2'd3, 64'h0000_0003_4000_0777, 4'd2, 4'd7},
        // R5 long-mode 2 MB
        '{5'b11001, 1'b0, 64'h10000, 64'h0000_0080_4060_0888, 1'b0, 2'd1, 64'h0000_0000_0560_0888, 4'd3, 4'd5},
        // R8 non-canonical, four-level
        '{5'b11001, 1'b0, 64'h10000, 64'h0000_8000_0000_0000, 1'b1, 2'd0, 64'h0, 4'd0, 4'd8},
        // R9 canonical high half, absent top entry
        '{5'b11001, 1'b0, 64'h10000, 64'hFFFF_FF80_0000_0000, 1'b1, 2'd0, 64'h0, 4'd1, 4'd9},
        // R6 five-level
        '{5'b11011, 1'b0, 64'h20000, 64'h0001_0080_4020_1345, 1'b0, 2'd0, 64'h0000_000A_BCDE_F345, 4'd5, 4'd6},
        // R8 same address non-canonical at four levels
        '{5'b11001, 1'b0, 64'h10000, 64'h0001_0080_4020_1345, 1'b1, 2'd0, 64'h0, 4'd0, 4'd8},
        // R8 non-canonical, five-level
        '{5'b11011, 1'b0, 64'h20000, 64'h0100_0000_0000_0000, 1'b1, 2'd0, 64'h0, 4'd0, 4'd8},
        // R9 absent extended top entry
        '{5'b11000, 1'b0, 64'h3020, 64'h0000_0000_C000_0000, 1'b1, 2'd0, 64'h0, 4'd1, 4'd9},
        // R9 absent last-level entry
        '{5'b11001, 1'b0, 64'h10000, 64'h0000_0080_4020_2345, 1'b1, 2'd0, 64'h0, 4'd4, 4'd9}
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            start;
    logic [63:0]     va;
    logic [PA_W-1:0] cr3;
    logic [PA_W-1:0] a20_mask;
    logic            pg_en, pae_en, pse_en, la57_en, lm_active;
    logic            mem_req;
    logic [PA_W-1:0] mem_addr;
    logic            mem_wide;
    logic            mem_rsp_valid;
    logic [63:0]     mem_rsp_data;
    logic            busy, done, fault;
    logic [PA_W-1:0] pa;
    logic [1:0]      pg_size;

    always #(CLK_NS/2) clk = ~clk;

    ptw_top #(.PA_W(PA_W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .va            (va),
        .cr3           (cr3),
        .a20_mask      (a20_mask),
        .pg_en         (pg_en),
        .pae_en        (pae_en),
        .pse_en        (pse_en),
        .la57_en       (la57_en),
        .lm_active     (lm_active),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_wide      (mem_wide),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .busy          (busy),
        .done          (done),
        .fault         (fault),
        .pa            (pa),
        .pg_size       (pg_size)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model
    logic [63:0] mem [longint];
    int          reads;
    int          extra_delay = 0;
    int          wait_ctr = 0;
    logic        addr_moved;
    logic        last_wide;
    logic [PA_W-1:0] held_addr;

    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
                wait_ctr = 0;
            end else if (mem_req) begin
                if (wait_ctr == 0) held_addr = mem_addr;
                else if (mem_addr !== held_addr) addr_moved = 1'b1;
                if (wait_ctr < extra_delay) begin
                    wait_ctr++;
                end else begin
                    logic [63:0] d;
                    longint k;
                    k = longint'(mem_addr);
                    d = mem.exists(k) ? mem[k] : 64'd0;
                    if (!mem_wide) d = {32'b0, d[31:0]};
                    mem_rsp_data  = d;
                    mem_rsp_valid = 1'b1;
                    last_wide     = mem_wide;
                    reads++;
                    wait_ctr = 0;
                end
            end
        end
    end

    task automatic drive(input logic [4:0] ctl, input logic a20off, input logic [63:0] c3, input logic [63:0] v);
        pg_en     = ctl[4];
        pae_en    = ctl[3];
        pse_en    = ctl[2];
        la57_en   = ctl[1];
        lm_active = ctl[0];
        cr3       = PA_W'(c3);
        va        = v;
        a20_mask  = a20off ? ~(PA_W'(1) << 20) : '1;
    endtask

    task automatic run_walk(input vec_t v);
        int n;
        @(negedge clk);
        drive(v.ctl, v.a20_off, v.cr3, v.va);
        reads = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // 32-bit tables
        mem[64'h1004]     = 64'h0000_2001;
        mem[64'h200C]     = 64'h0005_5003;
        mem[64'h1008]     = 64'h0C42_4081;
        mem[64'h0C42_4000] = 64'h0007_7001;
        // extended tables
        mem[64'h3030]     = 64'h0000_0000_0000_4081;
        mem[64'h4008]     = 64'h0000_0000_0000_5001;
        mem[64'h5008]     = 64'h8000_0000_0006_6001;
        mem[64'h4010]     = 64'h0000_0012_3460_0081;
        // long-mode tables
        mem[64'h20008]    = 64'h0000_0000_0001_0001;
        mem[64'h10008]    = 64'h0000_0000_0001_1001;
        mem[64'h11008]    = 64'h0000_0000_0001_2001;
        mem[64'h11010]    = 64'h0000_0003_4000_0081;
        mem[64'h12008]    = 64'h0000_0000_0001_3001;
        mem[64'h12018]    = 64'h0000_0000_0560_0081;
        mem[64'h13008]    = 64'h0000_000A_BCDE_F001;

        addr_moved = 1'b0;
        last_wide  = 1'b0;
        start = 1'b0;
        drive(5'b00000, 1'b0, 64'h0, 64'h0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk("R12 reset busy", 64'(busy), 64'd0);
        chk("R12 reset done", 64'(done), 64'd0);
        chk("R12 reset mem_req", 64'(mem_req), 64'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = VECS[i];
            run_walk(v);
            tag = $sformatf("R%0d vec%0d", v.req, i);
            chk({tag, " done"}, 64'(done), 64'd1);
            chk({tag, " fault"}, 64'(fault), 64'(v.exp_fault));
            chk({tag, " pa"}, 64'(pa), v.exp_pa);
            if (!v.exp_fault) chk({tag, " size"}, 64'(pg_size), 64'(v.exp_size));
            chk({tag, " reads"}, 64'(reads), 64'(v.exp_reads));
            if (v.exp_reads != 0) chk({tag, " width"}, 64'(last_wide), 64'(v.ctl[3]));
        end

        // R12 done lasts one cycle
        run_walk(VECS[9]);
        @(negedge clk);
        chk("R12 done strobe single cycle", 64'(done), 64'd0);

        // R12 request held through wait states
        extra_delay = 3;
        addr_moved  = 1'b0;
        run_walk(VECS[9]);
        chk("R12 stalled walk pa", 64'(pa), 64'h0000_000A_BCDE_F345);
        chk("R12 stalled walk reads", 64'(reads), 64'd4);
        chk("R12 address held while waiting", 64'(addr_moved), 64'd0);
        extra_delay = 0;

        // R12 start during a walk is ignored
        begin
            int dones;
            logic [PA_W-1:0] last_pa;
            dones = 0;
            last_pa = '0;
            @(negedge clk);
            drive(VECS[9].ctl, 1'b0, VECS[9].cr3, VECS[9].va);
            reads = 0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            drive(5'b00000, 1'b0, 64'h0, 64'h0000_0000_0000_1234);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int c = 0; c < 40; c++) begin
                if (done) begin
                    dones++;
                    last_pa = pa;
                end
                @(negedge clk);
            end
            chk("R12 one completion for busy start", 64'(dones), 64'd1);
            chk("R12 busy start kept first walk", 64'(last_pa), 64'h0000_000A_BCDE_F345);
            chk("R12 busy start reads", 64'(reads), 64'd4);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule